// File: doc/BRIEF.md
# DMA Bus Grant Arbiter

This block decides which channel of a small multi-channel DMA engine owns the shared bus. Each channel raises a request and presents a priority (a smaller value is more urgent) and a word count. The count is captured when the channel is idle. The arbiter then moves that count in transfer units of at most `CHUNK_MAX` words. Each unit has a source (read) phase followed by a destination (write) phase of equal length. After every unit there is one idle cycle with no grant, and the bus is arbitrated again in that cycle.

A more urgent channel may take the bus from the current owner, but only while the owner is in its source phase. A destination phase, once started, always runs to its end, so a long unit holds the bus for up to `CHUNK_MAX` cycles. A preempted channel keeps its remaining count and starts again with a fresh source phase when it next wins. One mode input sets how channels of equal priority share the bus. In fixed order the lowest index wins. In rotating order the search starts just after the channel granted most recently.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset, `grant_o`, `src_o`, `dst_o` and `done_o` are all zero.
- R2: A channel whose remaining count is zero loads `len_i` as its remaining word count on the next edge when `req_i` is high. The request is not needed after that.
- R3: `grant_o` is registered and has at most one bit set. It is nonzero exactly when `src_o` or `dst_o` is high. From idle, it goes to the pending channel with the smallest priority value.
- R4: A granted unit is u = min(remaining, CHUNK_MAX) words. `src_o` is high for u cycles, then `dst_o` for u cycles, then one idle cycle follows. At that point the remaining count has dropped by u.
- R5: With `fair_mode_i`=0, among equal best priorities the lowest channel index wins.
- R6: With `fair_mode_i`=1, among equal best priorities the search runs from the index after the last granted channel, wrapping around. The search starts at channel 0 after reset.
- R7: During any source-phase cycle, if a pending channel has a strictly smaller priority value than the owner, the grant moves to that channel on the next edge and a new source phase starts. The preempted channel keeps its remaining count.
- R8: While `dst_o` is high, the grant never moves to another channel. A destination phase lasts at most `CHUNK_MAX` cycles.
- R9: `done_o[c]` is high for exactly one cycle, in the idle cycle after the unit that brings channel c's count to zero.
- R10: A request with `len_i`=0 is ignored, and that channel is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fair_mode_i | input | 1 | 0 = fixed tie order, 1 = rotating tie order |
| req_i | input | N_CH | Per-channel request |
| prio_i | input | N_CH*PRIO_W | Per-channel priority, channel c at bits [c*PRIO_W +: PRIO_W] |
| len_i | input | N_CH*LEN_W | Per-channel word count, channel c at bits [c*LEN_W +: LEN_W] |
| grant_o | output | N_CH | One-hot bus owner |
| src_o | output | 1 | Owner is in its source phase |
| dst_o | output | 1 | Owner is in its destination phase |
| done_o | output | N_CH | One-cycle completion pulse per channel |

## Verification
The bench builds the block with four channels, 3-bit priorities, 8-bit counts and `CHUNK_MAX`=4. With these values a single request spans several units, the last unit is shorter than the others, and lengths 0 and 1 occur under random stimulus. Four channels are enough for equal-priority groups to rotate and wrap past the top index. Preemption requests are issued at a sweep of offsets, so they land in both source and destination phases, including the last source cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SRC  = 2'd1,
      PH_DST  = 2'd2
   } phase_t;
endpackage

// File: rtl/dma_arb_pick.sv
// Combinational winner search over pending channels.
module dma_arb_pick #(
   parameter int N_CH   = 4,
   parameter int PRIO_W = 3,
   localparam int IW    = $clog2(N_CH)
) (
   input  logic [N_CH-1:0]        act_i,
   input  logic [N_CH*PRIO_W-1:0] prio_i,
   input  logic                   fair_i,
   input  logic [IW-1:0]          last_i,
   output logic                   valid_o,
   output logic [IW-1:0]          win_o,
   output logic [PRIO_W-1:0]      win_prio_o
);
   always_comb begin
      int base;
      valid_o    = 1'b0;
      win_o      = '0;
      win_prio_o = '1;
      base       = fair_i ? int'(last_i) + 1 : 0;
      for (int k = 0; k < N_CH; k++) begin
         int idx;
         idx = base + k;
         if (idx >= N_CH) idx = idx - N_CH;
         // strict '<' keeps the first channel found in search order (R5, R6)
         if (act_i[idx] && (!valid_o || (prio_i[idx*PRIO_W +: PRIO_W] < win_prio_o))) begin
            valid_o    = 1'b1;
            win_o      = IW'(idx);
            win_prio_o = prio_i[idx*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/dma_arb_chan.sv
// Per-channel remaining-count register with load and retire.
module dma_arb_chan #(
   parameter int LEN_W = 8,
   parameter int CW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             retire_i,
   input  logic [CW-1:0]    amt_i,
   output logic [LEN_W-1:0] rem_o,
   output logic             done_o
);
   logic [LEN_W-1:0] amt_ext;
   assign amt_ext = LEN_W'(amt_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (retire_i) begin
            rem_o  <= rem_o - amt_ext;
            done_o <= (rem_o == amt_ext);
         end else if ((rem_o == '0) && req_i && (len_i != '0)) begin
            rem_o <= len_i;
         end
      end
   end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int N_CH      = 4,
   parameter int PRIO_W    = 3,
   parameter int LEN_W     = 12,
   parameter int CHUNK_MAX = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fair_mode_i,
   input  logic [N_CH-1:0]        req_i,
   input  logic [N_CH*PRIO_W-1:0] prio_i,
   input  logic [N_CH*LEN_W-1:0]  len_i,
   output logic [N_CH-1:0]        grant_o,
   output logic                   src_o,
   output logic                   dst_o,
   output logic [N_CH-1:0]        done_o
);
   localparam int IW = $clog2(N_CH);
   localparam int CW = $clog2(CHUNK_MAX + 1);

   generate
      if (N_CH < 2)          begin : g_bad_n  $error("N_CH must be at least 2"); end
      if (PRIO_W < 1)        begin : g_bad_p  $error("PRIO_W must be at least 1"); end
      if (CHUNK_MAX < 1)     begin : g_bad_c  $error("CHUNK_MAX must be at least 1"); end
      if (LEN_W < CW)        begin : g_bad_l  $error("LEN_W too narrow for CHUNK_MAX"); end
   endgenerate

   phase_t               state_q;
   logic [CW-1:0]        cnt_q, unit_q;
   logic [IW-1:0]        owner_q, last_q;
   logic [N_CH*LEN_W-1:0] rem_flat;
   logic [N_CH-1:0]      act, retire;
   logic                 win_valid, unit_end, preempt;
   logic [IW-1:0]        win;
   logic [PRIO_W-1:0]    win_prio, own_prio;
   logic [LEN_W-1:0]     win_rem;
   logic [CW-1:0]        win_unit;

   // channel count registers
   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign act[g]    = (rem_flat[g*LEN_W +: LEN_W] != '0);
      assign retire[g] = (state_q == PH_DST) && unit_end && (owner_q == IW'(g));
      dma_arb_chan #(.LEN_W(LEN_W), .CW(CW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_i    (req_i[g]),
         .len_i    (len_i[g*LEN_W +: LEN_W]),
         .retire_i (retire[g]),
         .amt_i    (unit_q),
         .rem_o    (rem_flat[g*LEN_W +: LEN_W]),
         .done_o   (done_o[g])
      );
   end

   dma_arb_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_pick (
      .act_i      (act),
      .prio_i     (prio_i),
      .fair_i     (fair_mode_i),
      .last_i     (last_q),
      .valid_o    (win_valid),
      .win_o      (win),
      .win_prio_o (win_prio)
   );

   always_comb begin
      win_rem  = rem_flat[win*LEN_W +: LEN_W];
      win_unit = (win_rem > LEN_W'(CHUNK_MAX)) ? CW'(CHUNK_MAX) : win_rem[CW-1:0];
      own_prio = prio_i[owner_q*PRIO_W +: PRIO_W];
      unit_end = (cnt_q == unit_q - CW'(1));
      preempt  = (state_q == PH_SRC) && win_valid && (win_prio < own_prio);
   end

   // phase sequencer: grant moves only from idle or inside a source phase
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         unit_q  <= '0;
         owner_q <= '0;
         last_q  <= IW'(N_CH - 1);
         grant_o <= '0;
      end else begin
         if ((state_q == PH_IDLE && win_valid) || preempt) begin
            state_q <= PH_SRC;
            owner_q <= win;
            last_q  <= win;
            unit_q  <= win_unit;
            cnt_q   <= '0;
            grant_o <= N_CH'(1) << win;
         end else if (state_q == PH_SRC) begin
            if (unit_end) begin
               state_q <= PH_DST;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end else if (state_q == PH_DST) begin
            if (unit_end) begin
               state_q <= PH_IDLE;
               grant_o <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   assign src_o = (state_q == PH_SRC);
   assign dst_o = (state_q == PH_DST);
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
   parameter int N_CH      = 4,
   parameter int CHUNK_MAX = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] grant_o,
   input logic            src_o,
   input logic            dst_o,
   input logic [N_CH-1:0] done_o
);
   logic [15:0] dst_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     dst_run_q <= '0;
      else if (dst_o) dst_run_q <= dst_run_q + 16'd1;
      else            dst_run_q <= '0;
   end

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R3
   grant_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o != '0) == (src_o || dst_o)) && !(src_o && dst_o));

   // R8
   dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_o |=> (grant_o == $past(grant_o)) || (grant_o == '0));

   // R8
   dst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_o |-> (dst_run_q < 16'(CHUNK_MAX)));

   // R4
   dst_after_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dst_o) |-> $past(src_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o != '0) |=> ((done_o & $past(done_o)) == '0));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o != '0) |-> (grant_o == '0));
endmodule

bind dma_bus_arbiter dma_arb_chk #(.N_CH(N_CH), .CHUNK_MAX(CHUNK_MAX)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .grant_o (grant_o),
   .src_o   (src_o),
   .dst_o   (dst_o),
   .done_o  (done_o)
);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int PW  = 3;
   localparam int LW  = 8;
   localparam int CH  = 4;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fair = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N*PW-1:0] prio = '0;
   logic [N*LW-1:0] len = '0;
   logic [N-1:0]  grant, done;
   logic          src, dst;

   dma_bus_arbiter #(.N_CH(N), .PRIO_W(PW), .LEN_W(LW), .CHUNK_MAX(CH)) u_dut (
      .clk(clk), .rst_n(rst_n), .fair_mode_i(fair), .req_i(req), .prio_i(prio),
      .len_i(len), .grant_o(grant), .src_o(src), .dst_o(dst), .done_o(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;
   string tag = "R1";

   // ---------------- behavioural reference model ----------------
   int m_rem [N];
   int m_state, m_cnt, m_unit, m_own, m_last;
   logic [N-1:0] m_done;
   int m_preempts = 0;

   function automatic int prio_of(int c);
      return int'(prio[c*PW +: PW]);
   endfunction

   // returns winner index or -1
   function automatic int choose();
      int order [$];
      int best = -1;
      for (int k = 1; k <= N; k++) order.push_back(fair ? (m_last + k) % N : k - 1);
      foreach (order[i]) begin
         int c = order[i];
         if (m_rem[c] != 0 && (best < 0 || prio_of(c) < prio_of(best))) best = c;
      end
      return best;
   endfunction

   task automatic m_take(int w);
      m_own = w; m_last = w; m_cnt = 0; m_state = 1;
      m_unit = (m_rem[w] > CH) ? CH : m_rem[w];
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_rem[c]) m_rem[c] = 0;
         m_state = 0; m_cnt = 0; m_unit = 0; m_own = 0; m_last = N - 1; m_done = '0;
      end else begin
         int w, retire, old_unit;
         w = choose(); retire = -1; old_unit = m_unit;
         case (m_state)
            0: if (w >= 0) m_take(w);
            1: if (w >= 0 && prio_of(w) < prio_of(m_own)) begin
                  m_take(w); m_preempts++;
               end else if (m_cnt == m_unit - 1) begin
                  m_state = 2; m_cnt = 0;
               end else m_cnt++;
            default: if (m_cnt == m_unit - 1) begin
                  retire = m_own; m_state = 0;
               end else m_cnt++;
         endcase
         m_done = '0;
         for (int c = 0; c < N; c++) begin
            if (c == retire) begin
               m_rem[c] -= old_unit;
               if (m_rem[c] == 0) m_done[c] = 1'b1;
            end else if (m_rem[c] == 0 && req[c] && len[c*LW +: LW] != 0) begin
               m_rem[c] = int'(len[c*LW +: LW]);
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   logic [N-1:0] prev_grant = '0;
   bit prev_dst = 0;
   int dut_switches = 0;
   bit ch3_granted = 0;

   task automatic chk(bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [N-1:0] eg;
         eg = (m_state != 0) ? (N'(1) << m_own) : '0;
         // R3 / R5 / R6 / R7 owner, R4 phases, R9 done
         chk(grant == eg, "R3 grant", grant, eg);
         chk({src, dst} == {m_state == 1, m_state == 2}, "R4 phase", {src, dst},
             {m_state == 1, m_state == 2});
         chk(done == m_done, "R9 done", done, m_done);
         // R8: no owner change while in destination phase
         if (prev_dst && dst) chk(grant == prev_grant, "R8 dst hold", grant, prev_grant);
         if (prev_grant != '0 && grant != '0 && grant != prev_grant) dut_switches++;
         if (grant[3]) ch3_granted = 1;
         prev_grant = grant; prev_dst = dst;
      end
   end

   task automatic set_ch(int c, int p, int l);
      prio[c*PW +: PW] = PW'(p);
      len[c*LW +: LW]  = LW'(l);
   endtask

   task automatic pulse(logic [N-1:0] m);
      @(negedge clk); req = m;
      @(negedge clk); req = '0;
   endtask

   task automatic drain();
      int t = 0;
      while ((grant != '0 || u_dut.grant_o != '0 || m_state != 0 || m_rem[0] + m_rem[1] + m_rem[2] + m_rem[3] != 0) && t < 500) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] lfsr;
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (grant != '0 || src || dst || done != '0) begin
         errors++;
         $display("FAIL R1 reset outputs actual=%h expected=0", {grant, src, dst, done});
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(grant == '0 && done == '0, "R1 after reset", grant, 0);

      // R2 / R4: one channel, 6 words -> units of 4 and 2
      tag = "R2";
      set_ch(1, 3, 6);
      pulse(4'b0010);
      drain();

      // R4: single-word requests released after each word
      tag = "R4";
      set_ch(0, 2, 1); set_ch(2, 2, 1);
      pulse(4'b0101);
      drain();

      // R7 / R8: urgent channel arrives at swept offsets into a long burst
      tag = "R7";
      fair = 1'b0;
      for (int off = 0; off < 12; off++) begin
         set_ch(2, 5, 9); set_ch(0, 1, 2);
         pulse(4'b0100);
         repeat (off) @(negedge clk);
         pulse(4'b0001);
         drain();
      end

      // R5: equal priorities, fixed order
      tag = "R5";
      set_ch(1, 4, 3); set_ch(2, 4, 3); set_ch(3, 4, 3);
      pulse(4'b1110);
      drain();

      // R6: equal priorities, rotating order with continuous requests
      tag = "R6";
      fair = 1'b1;
      set_ch(0, 4, 2); set_ch(1, 4, 2); set_ch(2, 4, 2); set_ch(3, 4, 2);
      @(negedge clk); req = 4'b1111;
      repeat (60) @(negedge clk);
      req = '0;
      drain();

      // R10: zero-length request never granted
      tag = "R10";
      ch3_granted = 0;
      set_ch(3, 0, 0); set_ch(1, 6, 3);
      @(negedge clk); req = 4'b1010;
      repeat (20) @(negedge clk);
      req = '0;
      drain();
      chk(!ch3_granted, "R10 zero-length granted", ch3_granted, 0);

      // mixed random traffic, mode toggled periodically
      tag = "R3";
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         req = lfsr[3:0] & lfsr[7:4];
         if (lfsr[8]) set_ch(int'(lfsr[10:9]), int'(lfsr[13:11]), int'(lfsr[15:12]) % 12);
         if (i % 300 == 0) fair = ~fair;
      end
      req = '0;
      drain();

      // R7: every preemption seen at the ports matches the model, and some occurred
      tag = "R7";
      chk(dut_switches == m_preempts, "R7 preemption count", dut_switches, m_preempts);
      chk(m_preempts > 0, "R7 preemption exercised", m_preempts, 1);

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog %s actual=timeout expected=finish", tag);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule